// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block is one channel of a memory-to-memory mover. Once started, it reads a four-word descriptor from memory: the link to the next descriptor, the source address, the target address and a command word. It then copies the requested number of bytes in bursts. Each burst reads every beat into a local buffer before it writes any of them. When a descriptor's length is used up, the engine follows the link to the next descriptor, unless the link carries a stop marker.

A compare-status input can steer a fetch to an alternate descriptor placed 32 bytes after the normal one. A peripheral request input paces transfers that are marked flow-controlled. When that request is found low after a burst, the engine raises an end-of-receive event and, depending on two enables, either halts or jumps to the next descriptor. A no-fetch mode runs a single transfer from values given on input ports and reads no descriptor.

Start, end, end-of-receive and stop events are single-cycle pulses, meant to be gathered by an interrupt block outside this one. Command bits that select compare or fly-by operation have no effect.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, busy_o is 0, mem_req_o is 0 and all four event pulses are 0.
- R2: A descriptor is fetched as four single-word reads (mem_size_o = 2) at base, base+4, base+8 and base+12, where base is the link pointer with bits 3:0 cleared. The words are taken as link, source, target, command. Each read waits for its mem_ready_i before the next access is issued.
- R3: When link bit 1 and cmp_st_i are both 1 at the moment a fetch begins, the fetch base is increased by 32.
- R4: When the remaining length is zero, the engine checks link bit 0. If it is 1 (or the engine is in no-fetch mode), the engine pulses ev_stop_o and busy_o falls. Otherwise it fetches the descriptor that the link points to.
- R5: The command word carries the length in bytes in bits 12:0. Bits 15:14 select the access width: code 1 is 1 byte, code 2 is 2 bytes, codes 3 and 0 are 4 bytes (mem_size_o 0, 1, 2). Bits 17:16 select a burst of 4 shifted left by the code, in bytes.
- R6: Command bit 31 makes the source address advance by the width after each read, and bit 30 does the same for the target address after each write. When the bit is clear, that address stays fixed.
- R7: Each burst moves the smaller of the remaining length and the burst size, as ceil(bytes/width) beats. All reads of a burst precede its writes, and each write carries the data of the matching read. The remaining length is written back into cmd_o[12:0].
- R8: Command bit 29 marks the source as flow-controlled and bit 28 marks the target. At fetch, a marked address has its bits 1:0 cleared. While either bit is set, a burst begins only when dreq_i is 1.
- R9: If a flow-controlled burst ends with dreq_i at 0, ev_eor_o pulses. If eor_stop_en_i is 1, the engine then stops with ev_stop_o. Otherwise, if eor_jmp_en_i is 1 and the engine is not in no-fetch mode, it fetches the next descriptor.
- R10: ev_start_o pulses when a descriptor with command bit 22 has been loaded. ev_end_o pulses when the length reaches zero and command bit 21 is 1.
- R11: In no-fetch mode (nofetch_i at start), the engine takes src_i, dst_i and cmd_i directly, issues no descriptor read, and stops once the length reaches zero.
- R12: A zero-length command produces no data reads or writes; it completes with the end and stop handling of R4 and R10.
- R13: A rising edge on run_i starts the channel. If run_i is 0 when a burst is due to begin, the engine stops with ev_stop_o and keeps the remaining length.
- R14: While mem_req_o is 1 and mem_ready_i is 0, the request, direction and address hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run_i | input | 1 | Run control; a rising edge starts the channel, a low level stops it at a burst boundary |
| nofetch_i | input | 1 | Start in no-fetch mode |
| cmp_st_i | input | 1 | Compare status, used to select the alternate descriptor |
| eor_stop_en_i | input | 1 | Stop on end-of-receive |
| eor_jmp_en_i | input | 1 | Jump to the next descriptor on end-of-receive |
| desc_ptr_i | input | AW | First link pointer |
| src_i | input | AW | Source address for no-fetch mode |
| dst_i | input | AW | Target address for no-fetch mode |
| cmd_i | input | 32 | Command word for no-fetch mode |
| dreq_i | input | 1 | Peripheral request |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Access byte address |
| mem_size_o | output | 2 | Access size as log2 of bytes |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Access accepted or completed this cycle |
| busy_o | output | 1 | Channel active |
| next_o | output | AW | Current link pointer |
| src_o | output | AW | Current source address |
| dst_o | output | AW | Current target address |
| cmd_o | output | 32 | Current command word with the remaining length |
| ev_start_o | output | 1 | Start event pulse |
| ev_end_o | output | 1 | End event pulse |
| ev_eor_o | output | 1 | End-of-receive event pulse |
| ev_stop_o | output | 1 | Stop event pulse |

## Verification
Random chains of one to four linked descriptors, with random widths, burst codes, increment bits, lengths (zero included) and compare status, are compared access by access against a bench model. This tells apart errors in fetch-base masking, alternate selection, beat counting and address stepping, under a memory that randomly delays each response. Directed flow-controlled runs hold the request low and then drop it mid-transfer, which separates gating at the start of a burst from the end-of-receive stop path and the jump path. A no-fetch run of zero length and a long run cut short by run_i separate the shortcut paths from normal completion.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_CHECK,
      ST_READ,
      ST_WRITE,
      ST_POST
   } eng_state_e;

   // command word bit positions
   localparam int CMD_SRC_INC  = 31;
   localparam int CMD_DST_INC  = 30;
   localparam int CMD_SRC_FLOW = 29;
   localparam int CMD_DST_FLOW = 28;
   localparam int CMD_START_EV = 22;
   localparam int CMD_END_EV   = 21;
   localparam int CMD_WID_LO   = 14;
   localparam int CMD_BST_LO   = 16;

   // link pointer bit positions
   localparam int LNK_STOP = 0;
   localparam int LNK_ALT  = 1;

   function automatic logic [1:0] width_log2(input logic [1:0] code);
      case (code)
         2'd1:    return 2'd0;
         2'd2:    return 2'd1;
         default: return 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          align,
   input  logic          step,
   input  logic          inc,
   input  logic [1:0]    wlog,
   output logic [AW-1:0] addr_o
);
   logic [AW-1:0] addr_q;
   logic [AW-1:0] stride;

   assign stride = AW'(1) << wlog;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load) begin
         addr_q <= load_val;
      end else if (align) begin
         addr_q[1:0] <= 2'b00;
      end else if (step && inc) begin
         addr_q <= addr_q + stride;
      end
   end

   assign addr_o = addr_q;
endmodule

// File: rtl/dma_burst_calc.sv
module dma_burst_calc #(
   parameter int LEN_W  = 13,
   parameter int BEAT_W = 6
) (
   input  logic [LEN_W-1:0]  len,
   input  logic [1:0]        wid_code,
   input  logic [1:0]        bst_code,
   output logic [1:0]        wlog,
   output logic [LEN_W-1:0]  burst_bytes,
   output logic [BEAT_W-1:0] beats
);
   import dma_chain_pkg::*;

   logic [LEN_W-1:0] size_bytes;
   logic [LEN_W-1:0] round_up;
   logic [LEN_W:0]   padded;

   always_comb begin
      wlog        = width_log2(wid_code);
      size_bytes  = LEN_W'(4) << bst_code;
      burst_bytes = (len < size_bytes) ? len : size_bytes;
      round_up    = (LEN_W'(1) << wlog) - LEN_W'(1);
      padded      = {1'b0, burst_bytes} + {1'b0, round_up};
      beats       = BEAT_W'(padded >> wlog);
   end
endmodule

// File: rtl/dma_burst_buf.sv
module dma_burst_buf #(
   parameter int DW    = 32,
   parameter int DEPTH = 32
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] widx,
   input  logic [DW-1:0]            wdata,
   input  logic [$clog2(DEPTH)-1:0] ridx,
   output logic [DW-1:0]            rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[widx] <= wdata;
   end

   assign rdata = mem[ridx];
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int LEN_W     = 13,
   parameter int MAX_BURST = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          nofetch_i,
   input  logic          cmp_st_i,
   input  logic          eor_stop_en_i,
   input  logic          eor_jmp_en_i,
   input  logic [AW-1:0] desc_ptr_i,
   input  logic [AW-1:0] src_i,
   input  logic [AW-1:0] dst_i,
   input  logic [31:0]   cmd_i,
   input  logic          dreq_i,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [1:0]    mem_size_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic [DW-1:0] mem_rdata_i,
   input  logic          mem_ready_i,
   output logic          busy_o,
   output logic [AW-1:0] next_o,
   output logic [AW-1:0] src_o,
   output logic [AW-1:0] dst_o,
   output logic [31:0]   cmd_o,
   output logic          ev_start_o,
   output logic          ev_end_o,
   output logic          ev_eor_o,
   output logic          ev_stop_o
);
   import dma_chain_pkg::*;

   localparam int BEAT_W = $clog2(MAX_BURST + 1);
   localparam int IDX_W  = $clog2(MAX_BURST);

   initial begin
      assert (AW == DW) else $error("AW must equal DW");
      assert (DW == 32) else $error("descriptor words are 32 bits");
      assert (LEN_W > 0 && LEN_W <= 14) else $error("length must fit below the width field");
      assert (MAX_BURST >= 32) else $error("buffer must hold a 32-beat burst");
   end

   eng_state_e         state_q;
   logic               run_q, mode_q;
   logic [AW-1:0]      next_q, fbase_q;
   logic [31:0]        cmd_q;
   logic [1:0]         fidx_q;
   logic [BEAT_W-1:0]  beat_q, beats_q;
   logic [LEN_W-1:0]   burst_q;

   logic               start, hs, flow, last_beat;
   logic [LEN_W-1:0]   len;
   logic [1:0]         wlog;
   logic [LEN_W-1:0]   calc_burst;
   logic [BEAT_W-1:0]  calc_beats;
   logic [AW-1:0]      src_addr, dst_addr;
   logic               fetch_ld, fetch_last;

   function automatic logic [AW-1:0] fetch_base(input logic [AW-1:0] p, input logic cmp);
      logic [AW-1:0] b;
      b = {p[AW-1:4], 4'b0000};
      if (p[LNK_ALT] && cmp) b = b + AW'(32);
      return b;
   endfunction

   assign start      = run_i && !run_q;
   assign len        = cmd_q[LEN_W-1:0];
   assign flow       = cmd_q[CMD_SRC_FLOW] || cmd_q[CMD_DST_FLOW];
   assign hs         = mem_req_o && mem_ready_i;
   assign last_beat  = (beat_q == beats_q - BEAT_W'(1));
   assign fetch_ld   = (state_q == ST_FETCH) && mem_ready_i;
   assign fetch_last = fetch_ld && (fidx_q == 2'd3);

   dma_burst_calc #(.LEN_W(LEN_W), .BEAT_W(BEAT_W)) u_calc (
      .len        (len),
      .wid_code   (cmd_q[CMD_WID_LO +: 2]),
      .bst_code   (cmd_q[CMD_BST_LO +: 2]),
      .wlog       (wlog),
      .burst_bytes(calc_burst),
      .beats      (calc_beats)
   );

   dma_addr_step #(.AW(AW)) u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    ((state_q == ST_IDLE && start && nofetch_i) || (fetch_ld && fidx_q == 2'd1)),
      .load_val((state_q == ST_IDLE) ? src_i : mem_rdata_i),
      .align   (fetch_last && mem_rdata_i[CMD_SRC_FLOW]),
      .step    (state_q == ST_READ && mem_ready_i),
      .inc     (cmd_q[CMD_SRC_INC]),
      .wlog    (wlog),
      .addr_o  (src_addr)
   );

   dma_addr_step #(.AW(AW)) u_dst (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    ((state_q == ST_IDLE && start && nofetch_i) || (fetch_ld && fidx_q == 2'd2)),
      .load_val((state_q == ST_IDLE) ? dst_i : mem_rdata_i),
      .align   (fetch_last && mem_rdata_i[CMD_DST_FLOW]),
      .step    (state_q == ST_WRITE && mem_ready_i),
      .inc     (cmd_q[CMD_DST_INC]),
      .wlog    (wlog),
      .addr_o  (dst_addr)
   );

   dma_burst_buf #(.DW(DW), .DEPTH(MAX_BURST)) u_buf (
      .clk  (clk),
      .we   (state_q == ST_READ && mem_ready_i),
      .widx (IDX_W'(beat_q)),
      .wdata(mem_rdata_i),
      .ridx (IDX_W'(beat_q)),
      .rdata(mem_wdata_o)
   );

   always_comb begin
      mem_req_o  = (state_q == ST_FETCH) || (state_q == ST_READ) || (state_q == ST_WRITE);
      mem_we_o   = (state_q == ST_WRITE);
      mem_size_o = (state_q == ST_FETCH) ? 2'd2 : wlog;
      case (state_q)
         ST_FETCH: mem_addr_o = fbase_q + AW'({fidx_q, 2'b00});
         ST_READ:  mem_addr_o = src_addr;
         ST_WRITE: mem_addr_o = dst_addr;
         default:  mem_addr_o = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         run_q      <= 1'b0;
         mode_q     <= 1'b0;
         next_q     <= '0;
         fbase_q    <= '0;
         cmd_q      <= '0;
         fidx_q     <= '0;
         beat_q     <= '0;
         beats_q    <= '0;
         burst_q    <= '0;
         ev_start_o <= 1'b0;
         ev_end_o   <= 1'b0;
         ev_eor_o   <= 1'b0;
         ev_stop_o  <= 1'b0;
      end else begin
         run_q      <= run_i;
         ev_start_o <= 1'b0;
         ev_end_o   <= 1'b0;
         ev_eor_o   <= 1'b0;
         ev_stop_o  <= 1'b0;
         case (state_q)
            ST_IDLE: if (start) begin
               mode_q <= nofetch_i;
               next_q <= desc_ptr_i;
               if (nofetch_i) begin
                  cmd_q   <= cmd_i;
                  state_q <= ST_CHECK;
               end else begin
                  fbase_q <= fetch_base(desc_ptr_i, cmp_st_i);
                  fidx_q  <= 2'd0;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: if (mem_ready_i) begin
               fidx_q <= fidx_q + 2'd1;
               if (fidx_q == 2'd0) next_q <= mem_rdata_i;
               if (fidx_q == 2'd3) begin
                  cmd_q      <= mem_rdata_i;
                  ev_start_o <= mem_rdata_i[CMD_START_EV];
                  state_q    <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (!run_i) begin
                  ev_stop_o <= 1'b1;
                  state_q   <= ST_IDLE;
               end else if (len == '0) begin
                  ev_end_o <= cmd_q[CMD_END_EV];
                  if (next_q[LNK_STOP] || mode_q) begin
                     ev_stop_o <= 1'b1;
                     state_q   <= ST_IDLE;
                  end else begin
                     fbase_q <= fetch_base(next_q, cmp_st_i);
                     fidx_q  <= 2'd0;
                     state_q <= ST_FETCH;
                  end
               end else if (!flow || dreq_i) begin
                  beats_q <= calc_beats;
                  burst_q <= calc_burst;
                  beat_q  <= '0;
                  state_q <= ST_READ;
               end
            end
            ST_READ: if (mem_ready_i) begin
               if (last_beat) begin
                  beat_q  <= '0;
                  state_q <= ST_WRITE;
               end else begin
                  beat_q <= beat_q + BEAT_W'(1);
               end
            end
            ST_WRITE: if (mem_ready_i) begin
               if (last_beat) begin
                  cmd_q[LEN_W-1:0] <= len - burst_q;
                  state_q          <= ST_POST;
               end else begin
                  beat_q <= beat_q + BEAT_W'(1);
               end
            end
            ST_POST: begin
               ev_eor_o <= flow && !dreq_i;
               if (flow && !dreq_i && eor_stop_en_i) begin
                  ev_stop_o <= 1'b1;
                  state_q   <= ST_IDLE;
               end else if (flow && !dreq_i && eor_jmp_en_i && !mode_q && len != '0) begin
                  fbase_q <= fetch_base(next_q, cmp_st_i);
                  fidx_q  <= 2'd0;
                  state_q <= ST_FETCH;
               end else begin
                  state_q <= ST_CHECK;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign next_o = next_q;
   assign src_o  = src_addr;
   assign dst_o  = dst_addr;
   assign cmd_o  = cmd_q;

   // R14: a pending access holds its request, direction and address
   assert_req_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)));

   // R4: a stop pulse leaves the channel idle
   assert_stop_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop_o |-> !busy_o);

   // R7: completing a burst strictly lowers the remaining length
   assert_len_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WRITE && hs && last_beat) |=> (len < $past(len)));

   // R6: a non-incrementing source stays put across reads
   assert_fixed_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ && mem_ready_i && !cmd_q[CMD_SRC_INC]) |=> $stable(src_addr));

   // R10: a start pulse only follows the last descriptor word
   assert_start_after_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start_o |-> $past(state_q == ST_FETCH && fidx_q == 2'd3));

   // R7: a burst never exceeds the buffer
   assert_beats_fit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ) |-> (beats_q <= BEAT_W'(MAX_BURST) && beats_q != '0));
endmodule

// File: tb/dma_chain_engine_tb.sv
module dma_chain_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_i = 1'b0, nofetch_i = 1'b0, cmp_st_i = 1'b0;
   logic        eor_stop_en_i = 1'b0, eor_jmp_en_i = 1'b0, dreq_i = 1'b0;
   logic [31:0] desc_ptr_i = '0, src_i = '0, dst_i = '0, cmd_i = '0;
   logic        mem_req_o, mem_we_o, mem_ready_i = 1'b0;
   logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
   logic [1:0]  mem_size_o;
   logic        busy_o, ev_start_o, ev_end_o, ev_eor_o, ev_stop_o;
   logic [31:0] next_o, src_o, dst_o, cmd_o;

   int n_chk = 0, n_fail = 0;
   int rdy_pct = 60;
   int n_start, n_end, n_eor, n_stop, n_wr;
   logic [31:0] dmem [256];
   logic        act_we[$], exp_we[$];
   logic [31:0] act_addr[$], act_data[$], exp_addr[$], exp_data[$];
   int exp_start, exp_end, exp_stop;

   always #2 clk = ~clk;

   dma_chain_engine u_dut (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .nofetch_i(nofetch_i), .cmp_st_i(cmp_st_i),
      .eor_stop_en_i(eor_stop_en_i), .eor_jmp_en_i(eor_jmp_en_i), .desc_ptr_i(desc_ptr_i),
      .src_i(src_i), .dst_i(dst_i), .cmd_i(cmd_i), .dreq_i(dreq_i),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_size_o(mem_size_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .mem_ready_i(mem_ready_i), .busy_o(busy_o), .next_o(next_o), .src_o(src_o),
      .dst_o(dst_o), .cmd_o(cmd_o), .ev_start_o(ev_start_o), .ev_end_o(ev_end_o),
      .ev_eor_o(ev_eor_o), .ev_stop_o(ev_stop_o)
   );

   function automatic logic [31:0] rd_fn(input logic [31:0] a);
      if (a >= 32'h1000 && a < 32'h1400) return dmem[a[9:2]];
      return (a * 32'h9E3779B1) ^ 32'h5A5A5A5A;
   endfunction

   always_comb mem_rdata_i = rd_fn(mem_addr_o);

   // memory responder and monitor: decide ready away from the clock edge
   always @(negedge clk) begin
      logic r;
      r = ($urandom % 100) < rdy_pct;
      mem_ready_i = r && rst_n;
      if (rst_n && mem_req_o && r) begin
         act_we.push_back(mem_we_o);
         act_addr.push_back(mem_addr_o);
         act_data.push_back(mem_we_o ? mem_wdata_o : mem_rdata_i);
         if (mem_we_o) n_wr++;
      end
      if (ev_start_o) n_start++;
      if (ev_end_o)   n_end++;
      if (ev_eor_o)   n_eor++;
      if (ev_stop_o)  n_stop++;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_all();
      act_we.delete(); act_addr.delete(); act_data.delete();
      exp_we.delete(); exp_addr.delete(); exp_data.delete();
      n_start = 0; n_end = 0; n_eor = 0; n_stop = 0; n_wr = 0;
      exp_start = 0; exp_end = 0; exp_stop = 0;
   endtask

   task automatic push_exp(input logic we, input logic [31:0] a, input logic [31:0] d);
      exp_we.push_back(we); exp_addr.push_back(a); exp_data.push_back(d);
   endtask

   task automatic put_desc(input logic [31:0] a, input logic [31:0] n, input logic [31:0] s,
                           input logic [31:0] d, input logic [31:0] c);
      dmem[a[9:2]]      = n;
      dmem[a[9:2] + 1]  = s;
      dmem[a[9:2] + 2]  = d;
      dmem[a[9:2] + 3]  = c;
   endtask

   // model of one transfer from the requirements (R5, R6, R7)
   task automatic model_xfer(input logic [31:0] s0, input logic [31:0] d0, input logic [31:0] c);
      logic [31:0] s, d, buffer [32];
      int len, w, bs, b, beats;
      s = s0; d = d0;
      len = int'(c[12:0]);
      w   = (c[15:14] == 2'd1) ? 1 : (c[15:14] == 2'd2) ? 2 : 4;
      bs  = 4 << c[17:16];
      while (len > 0) begin
         b = (len < bs) ? len : bs;
         beats = (b + w - 1) / w;
         for (int k = 0; k < beats; k++) begin
            buffer[k] = rd_fn(s);
            push_exp(1'b0, s, buffer[k]);
            if (c[31]) s = s + w;
         end
         for (int k = 0; k < beats; k++) begin
            push_exp(1'b1, d, buffer[k]);
            if (c[30]) d = d + w;
         end
         len = len - b;
      end
      if (c[21]) exp_end++;
   endtask

   task automatic model_chain(input logic [31:0] ptr, input logic cmp);
      logic [31:0] cur, base, n, s, d, c;
      cur = ptr;
      forever begin
         base = {cur[31:4], 4'b0000} + ((cur[1] && cmp) ? 32'd32 : 32'd0);
         for (int i = 0; i < 4; i++) push_exp(1'b0, base + 4 * i, rd_fn(base + 4 * i));
         n = rd_fn(base); s = rd_fn(base + 4); d = rd_fn(base + 8); c = rd_fn(base + 12);
         if (c[29]) s[1:0] = 2'b00;
         if (c[28]) d[1:0] = 2'b00;
         if (c[22]) exp_start++;
         model_xfer(s, d, c);
         if (n[0]) begin
            exp_stop++;
            break;
         end
         cur = n;
      end
   endtask

   task automatic do_run();
      run_i = 1'b1;
      @(negedge clk);
      while (busy_o) @(negedge clk);
      run_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic compare(input string tag);
      int n;
      chk(act_we.size() == exp_we.size(), {tag, " access count"}, act_we.size(), exp_we.size());
      n = (act_we.size() < exp_we.size()) ? act_we.size() : exp_we.size();
      for (int i = 0; i < n; i++) begin
         chk(act_we[i] == exp_we[i] && act_addr[i] == exp_addr[i] && act_data[i] == exp_data[i],
             {tag, " access"}, act_addr[i], exp_addr[i]);
      end
      chk(n_start == exp_start, {tag, " R10 start events"}, n_start, exp_start);
      chk(n_end == exp_end, {tag, " R10 end events"}, n_end, exp_end);
      chk(n_stop == exp_stop, {tag, " R4 stop events"}, n_stop, exp_stop);
      chk(n_eor == 0, {tag, " no eor"}, n_eor, 0);
   endtask

   function automatic logic [31:0] rnd_cmd();
      logic [31:0] c;
      c = '0;
      c[12:0]  = (($urandom % 5) == 0) ? 13'd0 : 13'($urandom % 100);
      c[15:14] = 2'($urandom);
      c[17:16] = 2'($urandom);
      c[31]    = 1'($urandom);
      c[30]    = 1'($urandom);
      c[22]    = 1'($urandom);
      c[21]    = 1'($urandom);
      return c;
   endfunction

   initial begin
      int unused_seed;
      int nd;
      logic [31:0] c, ptr;
      int rem;
      unused_seed = $urandom(32'h1F2E3D4C);
      for (int i = 0; i < 256; i++) dmem[i] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy_o == 1'b0, "R1 busy after reset", 32'(busy_o), 0);
      chk(mem_req_o == 1'b0, "R1 request after reset", 32'(mem_req_o), 0);
      chk({ev_start_o, ev_end_o, ev_eor_o, ev_stop_o} == 4'b0, "R1 events after reset",
          32'({ev_start_o, ev_end_o, ev_eor_o, ev_stop_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3: directed alternate-descriptor selection
      for (int alt = 0; alt < 2; alt++) begin
         clear_all();
         put_desc(32'h1000, 32'h1, 32'h4000, 32'h8000, 32'hC002_B010);
         put_desc(32'h1020, 32'h1, 32'h4100, 32'h8100, 32'hC000_C008);
         cmp_st_i = 1'(alt);
         desc_ptr_i = 32'h100E;
         model_chain(desc_ptr_i, cmp_st_i);
         do_run();
         chk(act_addr.size() > 0 && act_addr[0] == (alt ? 32'h1020 : 32'h1000),
             "R3 fetch base selection", act_addr.size() > 0 ? act_addr[0] : 0,
             alt ? 32'h1020 : 32'h1000);
         compare("R2 directed fetch");
      end

      // R11 R12: zero-length no-fetch run
      clear_all();
      nofetch_i = 1'b1; src_i = 32'h4000; dst_i = 32'h8000; cmd_i = 32'h0020_0000;
      do_run();
      chk(act_we.size() == 0, "R12 no accesses for zero length", act_we.size(), 0);
      chk(n_end == 1 && n_stop == 1, "R11 end and stop in no-fetch", n_end * 16 + n_stop, 32'h11);
      nofetch_i = 1'b0;

      // random chains and no-fetch transfers: R2 R3 R4 R5 R6 R7 R10 R11 R12
      for (int t = 0; t < 40; t++) begin
         clear_all();
         nd = 1 + ($urandom % 4);
         for (int k = 0; k < nd; k++) begin
            for (int a = 0; a < 2; a++) begin
               ptr = (k == nd - 1) ? (32'h1 | 32'($urandom % 16 & 32'hE))
                                   : (32'h1000 + 64 * (k + 1)) | 32'($urandom % 16 & 32'hE);
               put_desc(32'h1000 + 64 * k + 32 * a, ptr,
                        32'h4000 + 32'($urandom % 4096), 32'h8000 + 32'($urandom % 4096), rnd_cmd());
            end
         end
         cmp_st_i = 1'($urandom);
         if (($urandom % 5) == 0) begin
            nofetch_i = 1'b1;
            src_i = 32'h4000 + 32'($urandom % 4096);
            dst_i = 32'h8000 + 32'($urandom % 4096);
            cmd_i = rnd_cmd();
            model_xfer(src_i, dst_i, cmd_i);
            exp_stop++;
            do_run();
            compare("R11 no-fetch random");
            nofetch_i = 1'b0;
         end else begin
            desc_ptr_i = 32'h1000 | 32'($urandom % 16 & 32'hE);
            model_chain(desc_ptr_i, cmp_st_i);
            do_run();
            compare("R2/R3/R4/R5/R6/R7 chain");
            chk(cmd_o[12:0] == 13'd0, "R7 length written back", 32'(cmd_o[12:0]), 0);
         end
      end

      // R8 R9: flow control with end-of-receive stop
      rdy_pct = 100;
      clear_all();
      c = 32'hE000_0000 | 32'h0020_0000 | 32'h0000_C000 | 32'h0001_0000 | 32'd64;
      put_desc(32'h1100, 32'h1, 32'h4003, 32'h8000, c);
      desc_ptr_i = 32'h1100; cmp_st_i = 1'b0; eor_stop_en_i = 1'b1; dreq_i = 1'b0;
      run_i = 1'b1;
      repeat (40) @(negedge clk);
      chk(act_we.size() == 4, "R8 no burst while request low", act_we.size(), 4);
      dreq_i = 1'b1;
      while (n_wr < 4) @(negedge clk);
      dreq_i = 1'b0;
      while (busy_o) @(negedge clk);
      run_i = 1'b0;
      repeat (2) @(negedge clk);
      chk(act_addr.size() > 4 && act_addr[4] == 32'h4000, "R8 flow source aligned",
          act_addr.size() > 4 ? act_addr[4] : 0, 32'h4000);
      chk(n_eor == 1, "R9 eor event", n_eor, 1);
      chk(n_stop == 1 && n_end == 0, "R9 eor stop", n_stop * 16 + n_end, 32'h10);
      chk(n_wr % 2 == 0 && n_wr < 16, "R7 whole bursts", n_wr, 4);
      chk(32'(cmd_o[12:0]) == 32'(64 - 4 * n_wr), "R7 remaining length", 32'(cmd_o[12:0]), 32'(64 - 4 * n_wr));
      for (int i = 4; i + 3 < act_we.size(); i += 4) begin
         chk({act_we[i], act_we[i+1], act_we[i+2], act_we[i+3]} == 4'b0011,
             "R7 reads before writes", 32'({act_we[i], act_we[i+1], act_we[i+2], act_we[i+3]}), 3);
      end

      // R9: end-of-receive jump to the next descriptor
      clear_all();
      put_desc(32'h1100, 32'h1140, 32'h4000, 32'h8000, c);
      put_desc(32'h1140, 32'h1, 32'h5000, 32'h9000, 32'hC021_C008);
      eor_stop_en_i = 1'b0; eor_jmp_en_i = 1'b1; dreq_i = 1'b0;
      run_i = 1'b1;
      repeat (10) @(negedge clk);
      dreq_i = 1'b1;
      while (n_wr < 4) @(negedge clk);
      dreq_i = 1'b0;
      while (busy_o) @(negedge clk);
      run_i = 1'b0;
      repeat (2) @(negedge clk);
      chk(act_we.size() >= 8 && act_addr[act_addr.size() - 8] == 32'h1140 && !act_we[act_we.size() - 8],
          "R9 jump fetches next descriptor",
          act_addr.size() >= 8 ? act_addr[act_addr.size() - 8] : 0, 32'h1140);
      chk(act_addr.size() > 0 && act_addr[act_addr.size() - 1] == 32'h9004, "R9 jump target done",
          act_addr.size() > 0 ? act_addr[act_addr.size() - 1] : 0, 32'h9004);
      chk(n_eor == 1 && n_end == 1 && n_stop == 1, "R9 jump events",
          n_eor * 256 + n_end * 16 + n_stop, 32'h111);
      eor_jmp_en_i = 1'b0;

      // R13: run dropped mid-transfer
      clear_all();
      nofetch_i = 1'b1; src_i = 32'h4000; dst_i = 32'h8000;
      cmd_i = 32'hC003_4000 | 32'd4000;
      run_i = 1'b1;
      repeat (300) @(negedge clk);
      run_i = 1'b0;
      while (busy_o) @(negedge clk);
      repeat (2) @(negedge clk);
      rem = int'(cmd_o[12:0]);
      chk(n_stop == 1 && n_end == 0, "R13 stop without end", n_stop * 16 + n_end, 32'h10);
      chk(rem > 0 && rem < 4000 && (4000 - rem) % 32 == 0, "R13 stops at burst boundary", rem, 4000);
      chk(act_we.size() == 2 * (4000 - rem), "R13 accesses match moved bytes", act_we.size(), 2 * (4000 - rem));
      nofetch_i = 1'b0;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule